// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product A·B·R⁻¹ mod N for a large odd modulus N, where R = 2^WIDTH. The operands are handled as WORD_W-bit words. Two word multipliers work in parallel, and each has a pipeline latency of MUL_LAT cycles. One of them forms the operand partial products a_i·b_j. The other forms the reduction partial products q·n_j. A single adder of width 2·WORD_W+2 merges both products with the running sum and the word carry in one cycle.

Each outer word a_i starts with a quotient word q, found through two chained multiplies: the product with b_0, then the product with the supplied constant n' = −N⁻¹ mod 2^WORD_W. With this q, the lowest word of the running sum is zero and can be shifted out. Next, the inner words are issued one per cycle, so the multiplier latency overlaps across the inner loop. After the last outer word, a word-serial compare-and-subtract removes N at most once.

The block is a building unit for a modular exponentiation engine. The caller supplies A and B already reduced below N, together with n'. The caller pulses start and waits for the done pulse.

Top module: `mont_modmul`

## Requirements
- R1: With N odd, N < 2^WIDTH, A < N, B < N and n_prime_i equal to −N⁻¹ mod 2^WORD_W, the value on result_o at the done pulse is the unique r with 0 ≤ r < N and r·2^WIDTH ≡ A·B (mod N).
- R2: done_o is high for exactly one cycle. If start_i is sampled at clock edge 0, done_o is high in cycle NW·(3·MUL_LAT+NW+3)+2, where NW = WIDTH/WORD_W. This is 30 cycles for WIDTH=16, WORD_W=8, MUL_LAT=3.
- R3: After reset, done_o is 0 and result_o is all zeros.
- R4: A start_i pulse while a multiplication is in progress is ignored. The operands latched at the accepted start determine the result, and only one done pulse appears.
- R5: result_o changes only in the cycle where done_o is high, and holds its value until the next done pulse.
- R6: A zero operand (A = 0 or B = 0) yields result 0.
- R7: A start_i raised during the cycle where done_o is high is accepted. A new multiplication begins, and it keeps the latency of R2.
- R8: Operands at the edges of their range give correct results through the final subtraction. Covered cases are A = B = N−1, A = B = 1, moduli whose upper words are zero, and moduli near 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a multiplication when the block is idle |
| a_i | input | WIDTH | Operand A, latched at start |
| b_i | input | WIDTH | Operand B, latched at start |
| n_i | input | WIDTH | Odd modulus N, latched at start |
| n_prime_i | input | WORD_W | −N⁻¹ mod 2^WORD_W, latched at start |
| result_o | output | WIDTH | Montgomery product, valid from the done pulse |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle.

The first pair is the completion pulse and the acceptance of a new start. The bench raises start in the very cycle it sees done_o high. It then checks that a second result arrives at exactly the nominal latency with the new operands, while the first result stays on result_o until then.

The second pair is an in-flight computation and a stray start. The bench changes every operand input and pulses start midway through a run. It then judges that the result belongs to the original operands and that only one done pulse appears.

Results are compared arithmetically in the bench: r < N and r·2^WIDTH ≡ A·B (mod N). The sweep covers many odd moduli and operands.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_QA, ST_QAW, ST_QBW, ST_IN, ST_DR, ST_TOP, ST_SUB, ST_FIN
  } mm_state_e;

  // cycles from the accepting edge to the done cycle
  function automatic int mm_latency(int nw, int lat);
    return nw * (3 * lat + nw + 3) + 2;
  endfunction
endpackage

// File: rtl/mont_word_mul.sv
module mont_word_mul #(
  parameter int WORD_W  = 64,
  parameter int MUL_LAT = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  v_i,
  input  logic [WORD_W-1:0]     x_i,
  input  logic [WORD_W-1:0]     y_i,
  output logic                  v_o,
  output logic [2*WORD_W-1:0]   p_o
);
  localparam int PW = 2 * WORD_W;

  logic [PW-1:0] st_p [MUL_LAT];
  logic          st_v [MUL_LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_p[0] <= '0;
      st_v[0] <= 1'b0;
    end else begin
      st_p[0] <= {{WORD_W{1'b0}}, x_i} * {{WORD_W{1'b0}}, y_i};
      st_v[0] <= v_i;
    end
  end

  for (genvar s = 1; s < MUL_LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_p[s] <= '0;
        st_v[s] <= 1'b0;
      end else begin
        st_p[s] <= st_p[s-1];
        st_v[s] <= st_v[s-1];
      end
    end
  end

  assign p_o = st_p[MUL_LAT-1];
  assign v_o = st_v[MUL_LAT-1];
endmodule

// File: rtl/mont_acc_add.sv
module mont_acc_add #(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0]   t_i,
  input  logic [2*WORD_W-1:0] p0_i,
  input  logic [2*WORD_W-1:0] p1_i,
  input  logic [WORD_W+1:0]   c_i,
  output logic [WORD_W-1:0]   lo_o,
  output logic [WORD_W+1:0]   hi_o
);
  localparam int SW = 2 * WORD_W + 2;

  logic [SW-1:0] sum;

  always_comb begin
    sum = {{(WORD_W+2){1'b0}}, t_i} + {2'b00, p0_i} + {2'b00, p1_i}
        + {{WORD_W{1'b0}}, c_i};
    lo_o = sum[WORD_W-1:0];
    hi_o = sum[SW-1:WORD_W];
  end
endmodule

// File: rtl/mont_modmul.sv
module mont_modmul
  import mont_pkg::*;
#(
  parameter int WIDTH   = 1024,
  parameter int WORD_W  = 64,
  parameter int MUL_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [WIDTH-1:0]  n_i,
  input  logic [WORD_W-1:0] n_prime_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              done_o
);
  localparam int NW  = WIDTH / WORD_W;
  localparam int IW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int CWD = WORD_W + 2;
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  typedef logic [NW-1:0][WORD_W-1:0] vec_t;

  mm_state_e         st_q;
  vec_t              a_q, b_q, n_q, t_q, diff_q;
  logic [WORD_W-1:0] t_ext_q, np_q, q_q;
  logic [CWD-1:0]    c_q;
  logic              borrow_q;
  logic [IW-1:0]     i_q, j_q, k_q;

  // multiplier pair: [0] operand product, [1] reduction product
  logic                  m_v  [2];
  logic [WORD_W-1:0]     m_x  [2];
  logic [WORD_W-1:0]     m_y  [2];
  logic                  m_vo [2];
  logic [2*WORD_W-1:0]   m_p  [2];

  for (genvar m = 0; m < 2; m++) begin : g_mul
    mont_word_mul #(.WORD_W(WORD_W), .MUL_LAT(MUL_LAT)) u_mul (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (m_v[m]),
      .x_i   (m_x[m]),
      .y_i   (m_y[m]),
      .v_o   (m_vo[m]),
      .p_o   (m_p[m])
    );
  end

  logic [WORD_W-1:0]   u_w;
  logic                acc_en, top_step, acc_first_w;
  logic [WORD_W-1:0]   add_t, add_lo;
  logic [2*WORD_W-1:0] add_p0, add_p1;
  logic [CWD-1:0]      add_hi;
  logic [WORD_W-1:0]   sub_d;
  logic                sub_bo;
  logic [IW-1:0]       k_prev;

  always_comb begin
    u_w     = t_q[0] + m_p[0][WORD_W-1:0];
    m_x[0]  = a_q[i_q];
    m_y[0]  = b_q[j_q];
    m_v[0]  = (st_q == ST_QA) || (st_q == ST_IN);
    m_x[1]  = (st_q == ST_IN) ? q_q : u_w;
    m_y[1]  = (st_q == ST_IN) ? n_q[j_q] : np_q;
    m_v[1]  = (st_q == ST_IN) || ((st_q == ST_QAW) && m_vo[0]);
    acc_en  = ((st_q == ST_IN) || (st_q == ST_DR)) && m_vo[0];
    acc_first_w = acc_en && (k_q == '0);
    top_step = (st_q == ST_TOP);
    add_t   = top_step ? t_ext_q : t_q[k_q];
    add_p0  = top_step ? '0 : m_p[0];
    add_p1  = top_step ? '0 : m_p[1];
    k_prev  = k_q - 1'b1;
    {sub_bo, sub_d} = {1'b0, t_q[j_q]} - {1'b0, n_q[j_q]}
                    - {{WORD_W{1'b0}}, borrow_q};
  end

  mont_acc_add #(.WORD_W(WORD_W)) u_add (
    .t_i (add_t),
    .p0_i(add_p0),
    .p1_i(add_p1),
    .c_i (c_q),
    .lo_o(add_lo),
    .hi_o(add_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      n_q      <= '0;
      t_q      <= '0;
      diff_q   <= '0;
      t_ext_q  <= '0;
      np_q     <= '0;
      q_q      <= '0;
      c_q      <= '0;
      borrow_q <= 1'b0;
      i_q      <= '0;
      j_q      <= '0;
      k_q      <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (acc_en) begin
        if (k_q != '0) t_q[k_prev] <= add_lo;
        c_q <= add_hi;
        k_q <= (k_q == LAST) ? '0 : k_q + 1'b1;
      end
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          a_q     <= a_i;
          b_q     <= b_i;
          n_q     <= n_i;
          np_q    <= n_prime_i;
          t_q     <= '0;
          t_ext_q <= '0;
          i_q     <= '0;
          j_q     <= '0;
          k_q     <= '0;
          st_q    <= ST_QA;
        end
        ST_QA:  st_q <= ST_QAW;
        ST_QAW: if (m_vo[0]) st_q <= ST_QBW;
        ST_QBW: if (m_vo[1]) begin
          q_q  <= m_p[1][WORD_W-1:0];
          c_q  <= '0;
          j_q  <= '0;
          st_q <= ST_IN;
        end
        ST_IN: begin
          j_q <= (j_q == LAST) ? '0 : j_q + 1'b1;
          if (j_q == LAST) st_q <= ST_DR;
        end
        ST_DR: if (acc_en && (k_q == LAST)) st_q <= ST_TOP;
        ST_TOP: begin
          t_q[NW-1] <= add_lo;
          t_ext_q   <= add_hi[WORD_W-1:0];
          if (i_q == LAST) begin
            j_q      <= '0;
            borrow_q <= 1'b0;
            st_q     <= ST_SUB;
          end else begin
            i_q  <= i_q + 1'b1;
            st_q <= ST_QA;
          end
        end
        ST_SUB: begin
          diff_q[j_q] <= sub_d;
          borrow_q    <= sub_bo;
          j_q         <= (j_q == LAST) ? '0 : j_q + 1'b1;
          if (j_q == LAST) st_q <= ST_FIN;
        end
        ST_FIN: begin
          result_o <= ((t_ext_q != '0) || !borrow_q) ? diff_q : t_q;
          done_o   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_modmul_chk.sv
module mont_modmul_chk
  import mont_pkg::*;
#(
  parameter int WIDTH   = 1024,
  parameter int WORD_W  = 64,
  parameter int MUL_LAT = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [WIDTH-1:0]  result_o,
  input logic [WIDTH-1:0]  mod_q,
  input logic              acc_first,
  input logic [WORD_W-1:0] acc_lo
);
  localparam int EXP_D = mm_latency(WIDTH / WORD_W, MUL_LAT);

  logic bsy;
  int   cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsy <= 1'b0;
      cnt <= 0;
    end else if (start_i && (!bsy || done_o)) begin
      bsy <= 1'b1;
      cnt <= 1;
    end else if (done_o) begin
      bsy <= 1'b0;
    end else if (bsy) begin
      cnt <= cnt + 1;
    end
  end

  // R1: quotient word cancels the lowest word of each outer sum
  a_r1_low_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_first |-> (acc_lo == '0));

  a_r1_result_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o < mod_q));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4 / R7: done only for an accepted start, at the fixed latency
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bsy && (cnt == EXP_D)));

  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

bind mont_modmul mont_modmul_chk #(
  .WIDTH(WIDTH), .WORD_W(WORD_W), .MUL_LAT(MUL_LAT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .result_o (result_o),
  .mod_q    (n_q),
  .acc_first(acc_first_w),
  .acc_lo   (add_lo)
);

// File: tb/mont_modmul_bench.sv
module mont_modmul_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  WIDTH   = 16;
  localparam int  WORD_W  = 8;
  localparam int  MUL_LAT = 3;
  localparam int  NW      = WIDTH / WORD_W;
  localparam int  EXP_LAT = NW * (3 * MUL_LAT + NW + 3) + 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [WIDTH-1:0]  a_i = '0, b_i = '0, n_i = '0;
  logic [WORD_W-1:0] n_prime_i = '0;
  logic [WIDTH-1:0]  result_o;
  logic              done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mont_modmul #(.WIDTH(WIDTH), .WORD_W(WORD_W), .MUL_LAT(MUL_LAT)) u_mont_modmul (
    .clk_i, .rst_ni, .start_i, .a_i, .b_i, .n_i, .n_prime_i, .result_o, .done_o
  );

  function automatic logic [WORD_W-1:0] neg_inv(logic [WIDTH-1:0] nn);
    for (int x = 0; x < 256; x++)
      if (((int'(nn[7:0]) * x) & 255) == 255) return 8'(x);
    return '0;
  endfunction

  function automatic bit mont_ok(longint a, longint b, longint n, longint r);
    return (r < n) && (((r << WIDTH) % n) == ((a * b) % n));
  endfunction

  task automatic check(bit ok, string req, longint got, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [WIDTH-1:0] n);
    a_i = a; b_i = b; n_i = n; n_prime_i = neg_inv(n);
  endtask

  // start at a negedge, count cycles to done
  task automatic run(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [WIDTH-1:0] n,
                     string req);
    int lat;
    drive(a, b, n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < EXP_LAT + 40) begin
      @(negedge clk_i);
      lat++;
    end
    check(lat == EXP_LAT, "R2", lat, EXP_LAT);
    check(mont_ok(a, b, n, result_o), req, result_o, n);
    @(negedge clk_i);
    check(!done_o, "R2", done_o, 0);
  endtask

  initial begin
    int lat, pulses;
    logic [WIDTH-1:0] n, a, b, held;
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R3", done_o, 0);
    check(result_o == '0, "R3", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8 edge moduli and operands, R1 random sweep
    for (int m = 0; m < 14; m++) begin
      case (m)
        0: n = 16'h0003;  1: n = 16'h0005;  2: n = 16'h00FF;  3: n = 16'h0101;
        4: n = 16'h7FFF;  5: n = 16'h8001;  6: n = 16'hFFFF;  7: n = 16'hFFF1;
        8: n = 16'hABCD;  9: n = 16'h1235;
        default: n = 16'($urandom) | 16'h0001;
      endcase
      if (n < 3) n = 16'h0003;
      run(n - 1, n - 1, n, "R8");
      run(16'd1, 16'd1, n, "R8");
      run(n - 1, 16'd1, n, "R8");
      for (int p = 0; p < 12; p++)
        run(16'($urandom % n), 16'($urandom % n), n, "R1");
    end

    // R6 zero operands
    run(16'd0, 16'h1234, 16'hC001, "R6");
    check(result_o == '0, "R6", result_o, 0);
    run(16'h4321, 16'd0, 16'hC001, "R6");
    check(result_o == '0, "R6", result_o, 0);

    // R5 hold between pulses
    held = result_o;
    repeat (5) @(negedge clk_i);
    check(result_o == held, "R5", result_o, held);

    // R4 stray start mid-run with new inputs
    a = 16'h1357; b = 16'h2468; n = 16'hE00F;
    drive(a, b, n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1; pulses = 0;
    repeat (4) begin @(negedge clk_i); lat++; end
    drive(16'h0001, 16'h0001, 16'h0003);
    start_i = 1'b1;
    @(negedge clk_i); lat++;
    start_i = 1'b0;
    while (!done_o && lat < EXP_LAT + 40) begin @(negedge clk_i); lat++; end
    check(lat == EXP_LAT, "R4", lat, EXP_LAT);
    check(mont_ok(a, b, n, result_o), "R4", result_o, n);
    repeat (2 * EXP_LAT) begin
      @(negedge clk_i);
      if (done_o) pulses++;
    end
    check(pulses == 0, "R4", pulses, 0);

    // R7 start while done is high
    a = 16'h0ABC; b = 16'h0DEF; n = 16'h3001;
    drive(a, b, n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < EXP_LAT + 40) begin @(negedge clk_i); lat++; end
    check(mont_ok(a, b, n, result_o), "R7", result_o, n);
    held = result_o;
    a = 16'h2FFF; b = 16'h1001;
    drive(a, b, n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < EXP_LAT + 40) begin
      if (result_o != held) check(1'b0, "R5", result_o, held);
      @(negedge clk_i);
      lat++;
    end
    check(lat == EXP_LAT, "R7", lat, EXP_LAT);
    check(mont_ok(a, b, n, result_o), "R7", result_o, n);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule